// File: doc/BRIEF.md
# Filtered Low-Voltage Reset Sequencer

This block turns two raw reset causes into the single internal reset of a chip. One cause is an asynchronous, active-high flag from an analog supply comparator that says the supply has sagged. The other is an active-low external reset pin. Both inputs are brought into the system clock domain through flop chains. The external request acts at once. A supply-low request acts only after the flag has held without a break for a qualification time, so short dips have no effect.

Once every request has gone away, the chip reset stays high for a fixed number of further system clock cycles so that the oscillator can settle. If any request comes back during that count, the count starts again from zero. The output comes from a register and rises and falls only on the system clock edge. With a 4 MHz clock, a qualification time of 4000 cycles gives the nominal 1 ms filter, and 1024 cycles is the nominal settle time.

Top module: `lowv_reset_seq`

## Requirements
- R1: While `rst` is high, `chip_rst_o` is 1. After `rst` falls, with both inputs idle, `chip_rst_o` goes to 0 on the SETTLE_CYCLES-th rising edge.
- R2: Each input passes through a two-flop synchronizer. The supply-low request is qualified if `supply_low_i` is sampled high on QUAL_CYCLES consecutive rising edges. `chip_rst_o` is then 1 after the edge QUAL_CYCLES+3 edges from the first high sample. A flag held for fewer edges never raises `chip_rst_o`.
- R3: Any single edge that samples `supply_low_i` low clears the qualification progress. Two runs, each shorter than QUAL_CYCLES and separated by one low sample, cause no reset, even when their total exceeds QUAL_CYCLES.
- R4: Once qualified, the supply-low request stays active for as long as the synchronized flag stays high. It drops on the first edge that sees the synchronized flag low.
- R5: `ext_rst_n_i` is active low and needs no qualification. A low sampled at edge 1 makes `chip_rst_o` 1 after edge 3. The chip reset is the OR of the external request and the qualified supply-low request.
- R6: `chip_rst_o` falls only on the SETTLE_CYCLES-th consecutive edge at which no request is active. For an external low of L edges, `chip_rst_o` is 1 after edges 3 to L+1+SETTLE_CYCLES.
- R7: A request that comes back before the settle count finishes restarts the count from zero, and `chip_rst_o` does not drop in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-up reset of the sequencer |
| supply_low_i | input | 1 | Asynchronous supply-low flag from the comparator, active high |
| ext_rst_n_i | input | 1 | Asynchronous external reset pin, active low |
| chip_rst_o | output | 1 | Registered internal chip reset, active high |

## Verification
The bench builds the block with QUAL_CYCLES = 8 and SETTLE_CYCLES = 6. These small values let every dip length from one cycle up to well past the threshold be swept, and let every gap length between two external pulses, on both sides of the settle count, be tried. Short windows also allow the output to be compared against an arithmetic prediction on every cycle of every pattern. The cases covered are the exact edge of qualification, the split dip that would pass only if the filter were not continuous, and a settle count restarted at each possible point.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  // One flag per reset cause, ordered as they are synchronized.
  typedef struct packed {
    logic ext;
    logic lowv;
  } rst_src_t;

  localparam int unsigned NUM_SRC = 2;

endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
  parameter int unsigned WIDTH   = 2,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= RST_VAL;
        else     pipe[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= RST_VAL;
        else     pipe[g] <= pipe[g-1];
      end
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/rsq_lv_qual.sv
module rsq_lv_qual #(
  parameter int unsigned QUAL_CYCLES = 4000,
  localparam int unsigned QW = $clog2(QUAL_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lv_s,
  output logic          lv_rst,
  output logic [QW-1:0] qual_cnt
);

  localparam logic [QW-1:0] Q_LAST = QW'(QUAL_CYCLES - 1);
  localparam logic [QW-1:0] Q_FULL = QW'(QUAL_CYCLES);

  always_ff @(posedge clk) begin
    if (rst) begin
      qual_cnt <= '0;
      lv_rst   <= 1'b0;
    end else if (!lv_s) begin
      qual_cnt <= '0;
      lv_rst   <= 1'b0;
    end else begin
      if (qual_cnt != Q_FULL) qual_cnt <= qual_cnt + QW'(1);
      if (qual_cnt == Q_LAST) lv_rst <= 1'b1;
    end
  end

endmodule

// File: rtl/rsq_settle.sv
module rsq_settle #(
  parameter int unsigned SETTLE_CYCLES = 1024,
  localparam int unsigned SW = $clog2(SETTLE_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic src,
  output logic chip_rst
);

  localparam logic [SW-1:0] S_LAST = SW'(SETTLE_CYCLES - 1);

  logic [SW-1:0] settle_cnt;

  always_ff @(posedge clk) begin
    if (rst || src) begin
      settle_cnt <= '0;
      chip_rst   <= 1'b1;
    end else if (chip_rst) begin
      if (settle_cnt == S_LAST) chip_rst   <= 1'b0;
      else                      settle_cnt <= settle_cnt + SW'(1);
    end
  end

endmodule

// File: rtl/lowv_reset_seq.sv
module lowv_reset_seq
  import rsq_pkg::*;
#(
  parameter int unsigned QUAL_CYCLES   = 4000,
  parameter int unsigned SETTLE_CYCLES = 1024,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_low_i,
  input  logic ext_rst_n_i,
  output logic chip_rst_o
);

  localparam int unsigned QW = $clog2(QUAL_CYCLES + 1);

  logic [NUM_SRC-1:0] raw_req;
  logic [NUM_SRC-1:0] sync_req;
  rst_src_t           srcs;
  logic               lv_sync;
  logic               ext_sync;
  logic               lv_rst_q;
  logic [QW-1:0]      qual_cnt;
  logic               any_src;

  assign raw_req = {~ext_rst_n_i, supply_low_i};

  rsq_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_req),
    .q   (sync_req)
  );

  assign lv_sync  = sync_req[0];
  assign ext_sync = sync_req[1];

  rsq_lv_qual #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
    .clk      (clk),
    .rst      (rst),
    .lv_s     (lv_sync),
    .lv_rst   (lv_rst_q),
    .qual_cnt (qual_cnt)
  );

  assign srcs.lowv = lv_rst_q;
  assign srcs.ext  = ext_sync;
  assign any_src   = |srcs;

  rsq_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk      (clk),
    .rst      (rst),
    .src      (any_src),
    .chip_rst (chip_rst_o)
  );

endmodule

// File: rtl/rsq_checker.sv
module rsq_checker #(
  parameter int unsigned QUAL_CYCLES   = 4000,
  parameter int unsigned SETTLE_CYCLES = 1024,
  localparam int unsigned QW = $clog2(QUAL_CYCLES + 1),
  localparam int unsigned CW = $clog2(SETTLE_CYCLES + 2)
) (
  input logic          clk,
  input logic          rst,
  input logic          lv_s,
  input logic          lv_rst,
  input logic [QW-1:0] qual_cnt,
  input logic          src,
  input logic          chip_rst_o
);

  logic [CW-1:0] quiet_cnt;

  always_ff @(posedge clk) begin
    if (rst || src || !chip_rst_o) quiet_cnt <= '0;
    else if (quiet_cnt != CW'(SETTLE_CYCLES + 1)) quiet_cnt <= quiet_cnt + CW'(1);
  end

  // R1: reset forces the chip reset high
  p_reset_high_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> chip_rst_o);

  // R2: qualification appears only after a full count
  p_qual_full_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(lv_rst) |-> $past(qual_cnt) == QW'(QUAL_CYCLES - 1));

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    qual_cnt <= QW'(QUAL_CYCLES));

  // R3: a low sample wipes the qualification
  p_lv_clear_r3: assert property (@(posedge clk) disable iff (rst)
    !lv_s |=> (!lv_rst && qual_cnt == '0));

  // R4: qualified request is held while the flag stays high
  p_lv_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (lv_rst && lv_s) |=> lv_rst);

  // R5: any active request drives the chip reset next cycle
  p_src_asserts_r5: assert property (@(posedge clk) disable iff (rst)
    src |=> chip_rst_o);

  // R6: release only after a quiet edge, never past the settle length
  p_fall_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(chip_rst_o) |-> !$past(src));

  p_settle_len_r6: assert property (@(posedge clk) disable iff (rst)
    quiet_cnt <= CW'(SETTLE_CYCLES));

endmodule

bind lowv_reset_seq rsq_checker #(
  .QUAL_CYCLES   (QUAL_CYCLES),
  .SETTLE_CYCLES (SETTLE_CYCLES)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .lv_s       (lv_sync),
  .lv_rst     (lv_rst_q),
  .qual_cnt   (qual_cnt),
  .src        (any_src),
  .chip_rst_o (chip_rst_o)
);

// File: tb/tb_lowv_reset_seq.sv
`timescale 1ns/1ps
module tb_lowv_reset_seq;

  localparam int Q = 8;
  localparam int S = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_low_i = 1'b0;
  logic ext_rst_n_i  = 1'b1;
  logic chip_rst_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lowv_reset_seq #(.QUAL_CYCLES(Q), .SETTLE_CYCLES(S), .SYNC_STAGES(2)) dut (
    .clk          (clk),
    .rst          (rst),
    .supply_low_i (supply_low_i),
    .ext_rst_n_i  (ext_rst_n_i),
    .chip_rst_o   (chip_rst_o)
  );

  task automatic chk(input logic exp, input string req, input int k);
    checks++;
    if (chip_rst_o !== exp) begin
      errors++;
      $display("FAIL %s edge %0d: chip_rst_o=%b expected %b", req, k, chip_rst_o, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // R2/R4/R6: supply dip lasting L edges
  task automatic lv_pulse(input int l);
    supply_low_i = 1'b1;
    for (int k = 1; k <= l + S + Q + 8; k++) begin
      step();
      chk((l >= Q) && k >= Q + 3 && k <= l + 2 + S, "R2", k);
      if (k == l) supply_low_i = 1'b0;
    end
  endtask

  // R5/R6: external low for L edges
  task automatic ext_pulse(input int l);
    ext_rst_n_i = 1'b0;
    for (int k = 1; k <= l + S + 6; k++) begin
      step();
      chk(k >= 3 && k <= l + 1 + S, "R5", k);
      if (k == l) ext_rst_n_i = 1'b1;
    end
  endtask

  // R7: two external pulses separated by G high edges
  task automatic ext_double(input int l1, input int g, input int l2);
    logic exp;
    ext_rst_n_i = 1'b0;
    for (int k = 1; k <= l1 + g + l2 + S + 6; k++) begin
      step();
      if (g < S) exp = k >= 3 && k <= l1 + g + l2 + 1 + S;
      else exp = (k >= 3 && k <= l1 + 1 + S) ||
                 (k >= l1 + g + 3 && k <= l1 + g + l2 + 1 + S);
      chk(exp, "R7", k);
      if (k == l1) ext_rst_n_i = 1'b1;
      if (k == l1 + g) ext_rst_n_i = 1'b0;
      if (k == l1 + g + l2) ext_rst_n_i = 1'b1;
    end
  endtask

  initial begin
    // R1: reset state
    repeat (3) step();
    chk(1'b1, "R1", 0);
    rst = 1'b0;
    for (int k = 1; k <= S + 3; k++) begin
      step();
      chk(k <= S - 1, "R1", k);
    end

    // R2 and R4: sweep dip length across the threshold
    for (int l = 1; l <= Q + 12; l++) lv_pulse(l);

    // R3: split dip, each part short, total long
    supply_low_i = 1'b1;
    for (int k = 1; k <= 2 * Q + S + 6; k++) begin
      step();
      chk(1'b0, "R3", k);
      if (k == Q - 1) supply_low_i = 1'b0;
      if (k == Q) supply_low_i = 1'b1;
      if (k == 2 * Q - 1) supply_low_i = 1'b0;
    end

    // R5/R6: external pulse lengths
    for (int l = 1; l <= 5; l++) ext_pulse(l);

    // R5: OR of a held supply reset and a later external pulse
    supply_low_i = 1'b1;
    for (int k = 1; k <= Q + S + 22; k++) begin
      step();
      chk(k >= Q + 3 && k <= Q + 13 + S, "R5", k);
      if (k == Q + 6) supply_low_i = 1'b0;
      if (k == Q + 3) ext_rst_n_i = 1'b0;
      if (k == Q + 12) ext_rst_n_i = 1'b1;
    end

    // R7: settle restart at every gap length
    for (int g = 1; g <= S + 2; g++) ext_double(2, g, 2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule